// File: doc/BRIEF.md
# Alarm Flag and Interrupt Controller

This block keeps an 8-bit status register with two flags. One flag records that the timebase oscillator has halted. The other records that an external countdown has reached zero. The block turns the countdown event into an active-low interrupt line. A host clears the flags through a synchronous write port and reads them on a read port. Two inputs shape the interrupt. `irq_en` gates it. `pulse_mode` picks between two behaviours:

- **Level mode:** the line stays low for as long as the alarm flag is set.
- **Pulse mode:** the line drops for `PULSE_CYCLES` clocks, and the alarm flag clears itself when the pulse ends.

The interrupt is produced by a three-state machine:

- **ST_IDLE:** the line is high.
- **ST_LEVEL:** the line is low and follows the alarm flag.
- **ST_PULSE:** the line is low while a cycle counter runs down.

The transitions are:

- **Pulse start (any state to ST_PULSE):** taken on a countdown event when enable is 1 and pulse mode is selected. The counter is reloaded.
- **Level hold (ST_IDLE or ST_LEVEL to ST_LEVEL):** taken when enable is 1, level mode is selected and the next alarm flag value is 1.
- **Release (ST_LEVEL to ST_IDLE):** taken when the level condition drops.
- **Pulse end (ST_PULSE to ST_IDLE or ST_LEVEL):** taken when the counter is at zero. The next state follows the level condition.
- **Pulse count (ST_PULSE to ST_PULSE):** taken otherwise, and the counter decrements.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The read port shows the oscillator-halt flag at bit 7 and the alarm flag at bit 0. Bits 6 to 1 always read 0, whatever has been written.
- R2: An asserted `osc_halt` sets bit 7 at the next clock edge. Bit 7 then stays 1 until a write with bit 7 = 0. A write with bit 7 = 1 leaves it unchanged.
- R3: A `zero_evt` sets the alarm flag at the next clock edge, whatever the values of `irq_en` and `pulse_mode`.
- R4: A write with bit 0 = 0 clears the alarm flag at the next edge. A write with bit 0 = 1 leaves the flag unchanged.
- R5: When `zero_evt` and a clearing write fall in the same cycle, the alarm flag ends up set.
- R6: In level mode (`pulse_mode` = 0) with `irq_en` = 1, `irq_n` is 0 from the edge at which the alarm flag is 1. It returns to 1 at the edge at which the flag clears.
- R7: In pulse mode (`pulse_mode` = 1) with `irq_en` = 1, a `zero_evt` drives `irq_n` low for exactly `PULSE_CYCLES` clock cycles, starting at the next edge. The alarm flag clears at the same edge at which `irq_n` returns high.
- R8: A clearing write during a pulse clears the alarm flag but does not shorten the low pulse.
- R9: A new `zero_evt` during a pulse restarts it. `irq_n` stays low for `PULSE_CYCLES` cycles from the latest event, and the flag stays 1.
- R10: With `irq_en` = 0, a `zero_evt` leaves `irq_n` high. A pulse that is already running completes its full length.
- R11: While `por_n` = 0, the read port shows 8'h80 and `irq_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| osc_halt | input | 1 | Oscillator-halted indication |
| zero_evt | input | 1 | One-cycle strobe: countdown reached zero |
| irq_en | input | 1 | Interrupt enable |
| pulse_mode | input | 1 | 1 = pulse mode, 0 = level mode |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data (bit 7 halt flag, bit 0 alarm flag) |
| rd_data | output | 8 | Status register contents |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Every result is due at the first clock edge after the stimulus. This covers flag sets, flag clears, the fall of `irq_n` and the restart of a pulse. The one exception is the end of a pulse, which lands exactly `PULSE_CYCLES` edges after the last qualifying event. The bench drives inputs on the falling edge. At the rising edge it advances a behavioural model that counts the remaining pulse cycles as an integer. It then compares both outputs on the next falling edge, so every comparison sits exactly one edge after the stimulus it judges.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int STAT_W    = 8;
    localparam int HALT_BIT  = 7;
    localparam int ALARM_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEVEL = 2'd1,
        ST_PULSE = 2'd2
    } irq_state_e;
endpackage

// File: rtl/alarm_status_reg.sv
module alarm_status_reg
    import alarm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_halt,
    input  logic              zero_evt,
    input  logic              wr_en,
    input  logic              wr_halt_bit,
    input  logic              wr_alarm_bit,
    input  logic              pulse_done,
    output logic              alarm_next,
    output logic [STAT_W-1:0] status
);
    logic halt_q, halt_d;
    logic alarm_q;

    always_comb begin
        halt_d = halt_q;
        if (osc_halt)
            halt_d = 1'b1;
        else if (wr_en && !wr_halt_bit)
            halt_d = 1'b0;
    end

    // The set event has priority over both clear sources.
    always_comb begin
        alarm_next = alarm_q;
        if (zero_evt)
            alarm_next = 1'b1;
        else if (pulse_done)
            alarm_next = 1'b0;
        else if (wr_en && !wr_alarm_bit)
            alarm_next = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q  <= 1'b1;
            alarm_q <= 1'b0;
        end else begin
            halt_q  <= halt_d;
            alarm_q <= alarm_next;
        end
    end

    always_comb begin
        status            = '0;
        status[HALT_BIT]  = halt_q;
        status[ALARM_BIT] = alarm_q;
    end
endmodule

// File: rtl/alarm_irq_fsm.sv
module alarm_irq_fsm
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zero_evt,
    input  logic       irq_en,
    input  logic       pulse_mode,
    input  logic       alarm_next,
    output logic       pulse_done,
    output logic       cnt_zero,
    output irq_state_e state,
    output logic       irq_n
);
    localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    irq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pulse_start, level_req;

    always_comb begin
        pulse_start = irq_en && pulse_mode && zero_evt;
        level_req   = irq_en && !pulse_mode && alarm_next;
        cnt_zero    = (cnt_q == '0);
        pulse_done  = (state_q == ST_PULSE) && cnt_zero && !pulse_start;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pulse_start) begin
            state_d = ST_PULSE;
            cnt_d   = LOAD;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_LEVEL: state_d = level_req ? ST_LEVEL : ST_IDLE;
                ST_PULSE: begin
                    if (cnt_zero)
                        state_d = level_req ? ST_LEVEL : ST_IDLE;
                    else
                        cnt_d = cnt_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_LEVEL, ST_PULSE: irq_n = 1'b0;
            default:            irq_n = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        osc_halt,
    input  logic        zero_evt,
    input  logic        irq_en,
    input  logic        pulse_mode,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        irq_n
);
    logic       alarm_next;
    logic       pulse_done;
    logic       fsm_cnt_zero;
    irq_state_e fsm_state;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^wr_data[6:1];

    alarm_status_reg u_status (
        .clk          (clk),
        .rst_n        (por_n),
        .osc_halt     (osc_halt),
        .zero_evt     (zero_evt),
        .wr_en        (wr_en),
        .wr_halt_bit  (wr_data[HALT_BIT]),
        .wr_alarm_bit (wr_data[ALARM_BIT]),
        .pulse_done   (pulse_done),
        .alarm_next   (alarm_next),
        .status       (rd_data)
    );

    alarm_irq_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (por_n),
        .zero_evt   (zero_evt),
        .irq_en     (irq_en),
        .pulse_mode (pulse_mode),
        .alarm_next (alarm_next),
        .pulse_done (pulse_done),
        .cnt_zero   (fsm_cnt_zero),
        .state      (fsm_state),
        .irq_n      (irq_n)
    );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
    import alarm_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       osc_halt,
    input logic       zero_evt,
    input logic       irq_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq_n,
    input irq_state_e state,
    input logic       cnt_zero
);
    a_r1_zero_middle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:1] == 6'd0);

    a_r2_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        osc_halt |=> rd_data[7]);

    a_r2_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] && !(wr_en && !wr_data[7]) |=> rd_data[7]);

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> rd_data[0]);

    a_r4_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] && !zero_evt |=> !rd_data[0]);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt && wr_en && !wr_data[0] |=> rd_data[0]);

    a_r6_level_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LEVEL |-> rd_data[0] && !irq_n);

    a_r8_clear_keeps_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PULSE && !cnt_zero && wr_en && !wr_data[0] |=> !irq_n);

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en && irq_n |=> irq_n);
endmodule

bind alarm_irq_ctrl alarm_irq_chk chk_i (
    .clk      (clk),
    .rst_n    (por_n),
    .osc_halt (osc_halt),
    .zero_evt (zero_evt),
    .irq_en   (irq_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_n    (irq_n),
    .state    (fsm_state),
    .cnt_zero (fsm_cnt_zero)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
module alarm_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       osc_halt = 1'b0;
    logic       zero_evt = 1'b0;
    logic       irq_en = 1'b0;
    logic       pulse_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_n;

    alarm_irq_ctrl #(.PULSE_CYCLES(PULSE)) dut_i (
        .clk(clk), .por_n(por_n), .osc_halt(osc_halt), .zero_evt(zero_evt),
        .irq_en(irq_en), .pulse_mode(pulse_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string tag = "R11";
    int    m_halt = 1, m_alarm = 0, m_left = 0, m_low = 0;

    function automatic void model_step();
        bit start = irq_en && pulse_mode && zero_evt;
        bit ends  = 1'b0;
        if (!por_n) begin
            m_halt = 1; m_alarm = 0; m_left = 0; m_low = 0;
            return;
        end
        if (start) m_left = PULSE;
        else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) ends = 1'b1;
        end
        if (osc_halt) m_halt = 1;
        else if (wr_en && !wr_data[7]) m_halt = 0;
        if (zero_evt) m_alarm = 1;
        else if (ends) m_alarm = 0;
        else if (wr_en && !wr_data[0]) m_alarm = 0;
        m_low = (m_left > 0) || (irq_en && !pulse_mode && m_alarm == 1);
    endfunction

    task automatic compare();
        logic [7:0] exp_rd = {m_halt[0], 6'd0, m_alarm[0]};
        logic       exp_irq = !m_low[0];
        vectors++;
        if (rd_data !== exp_rd) begin
            miscompares++;
            $display("FAIL %s rd_data actual %02h expected %02h", tag, rd_data, exp_rd);
        end
        if (irq_n !== exp_irq) begin
            miscompares++;
            $display("FAIL %s irq_n actual %0b expected %0b", tag, irq_n, exp_irq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic apply(input bit we, input logic [7:0] d, input bit osc, input bit ze);
        wr_en = we; wr_data = d; osc_halt = osc; zero_evt = ze;
        tick();
        wr_en = 1'b0; wr_data = 8'h00; osc_halt = 1'b0; zero_evt = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired in %s", tag);
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R11"; compare(); idle(2);
        por_n = 1'b1;
        tag = "R1";  apply(1, 8'hFF, 0, 0); idle(1);
        tag = "R2";  apply(1, 8'h7F, 0, 0); apply(0, 8'h00, 1, 0); idle(2);
        apply(1, 8'h81, 0, 0); apply(1, 8'h01, 0, 0);
        // level mode
        irq_en = 1'b1; pulse_mode = 1'b0;
        tag = "R3";  apply(0, 8'h00, 0, 1);
        tag = "R6";  idle(3);
        tag = "R4";  apply(1, 8'hFF, 0, 0); idle(1); apply(1, 8'h00, 0, 0);
        tag = "R6";  idle(2);
        tag = "R5";  apply(1, 8'h00, 0, 1); idle(1); apply(1, 8'h00, 0, 0);
        tag = "R10"; irq_en = 1'b0; apply(0, 8'h00, 0, 1); idle(2);
        irq_en = 1'b1; tag = "R6"; idle(1); apply(1, 8'h80, 0, 0);
        // pulse mode
        pulse_mode = 1'b1;
        tag = "R7";  apply(0, 8'h00, 0, 1); idle(PULSE + 2);
        tag = "R8";  apply(0, 8'h00, 0, 1); idle(1); apply(1, 8'h00, 0, 0); idle(PULSE + 1);
        tag = "R9";  apply(0, 8'h00, 0, 1); idle(2); apply(0, 8'h00, 0, 1); idle(PULSE + 2);
        tag = "R10"; apply(0, 8'h00, 0, 1); idle(1); irq_en = 1'b0; idle(PULSE + 1);
        apply(0, 8'h00, 0, 1); idle(2); apply(1, 8'h00, 0, 0);
        tag = "R5";  irq_en = 1'b1; apply(1, 8'h00, 0, 1); idle(PULSE + 1);
        tag = "R11"; por_n = 1'b0; apply(0, 8'h00, 0, 1); idle(1);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule